// File: doc/BRIEF.md
# Macroblock Motion Detector

The block decides, frame by frame, whether a picture holds motion. It takes a stream of current and reference luma sample pairs, one macroblock after another in raster order. The stream is tagged with a marker on the last sample of each macroblock and a marker on the last macroblock of the frame. The decision is made in three steps. A sample pair is "different" when its absolute difference is above a pixel threshold. A macroblock is "moving" when it holds more different samples than a count threshold. A frame is a motion frame when more than a set number of enabled moving macroblocks were seen.

An area mask gives one enable bit to each 2x2 group of macroblocks. A persistence counter tracks how many frames in a row were free of motion and raises a motionless status once the run is long enough. A mode bit can use that status to deassert a record-enable output, which lets downstream logic skip still scenes. Thresholds, mode and mask are written through a byte-wide configuration port. Picture size, macroblock edge length and sample width are parameters; the defaults describe a picture 45 macroblocks wide and 30 tall, with 16x16 samples per macroblock.

Top module: `md_motion_detect`

## Requirements
- R1: A sample pair is different when |cur_smp - ref_smp| is strictly greater than the pixel threshold (6 bits, reset value 32, config address 0); equality does not count, and the sign of the difference does not matter.
- R2: A macroblock is moving when its number of different samples is strictly greater than the difference-count threshold (7 bits, reset value 32, config address 1).
- R3: motion_mb_count reports the number of moving, mask-enabled macroblocks in the last frame, and motion_frame is 1 when that number is strictly greater than the macroblock threshold (8 bits, reset value 5, config address 2).
- R4: Each frame without motion adds one to a still-run counter that saturates at 255; motionless is 1 once that counter is greater than or equal to the still threshold (8 bits, reset value 5, config address 3).
- R5: A motion frame sets the still-run counter to zero and clears motionless, in the same update that reports that frame.
- R6: Mask bit j (0-based, MSB-first) enables the 2x2 group in group row j / G and group column j mod G, where G is 8 times the number of bytes per group row: ceil(ceil(MB_COLS/2)/8) bytes. Bit 7 of a mask byte is the leftmost group that byte covers, and byte 0 bit 7 is the top-left group. A macroblock whose group bit is 0 never adds to motion_mb_count.
- R7: A write to config address 5 stores cfg_wdata as the mask byte at the write pointer and advances the pointer, wrapping after the last byte. A write to address 6 resets the pointer to byte 0. Written mask bytes take effect only from the frame after the next frame end. Reset leaves every mask bit at 1.
- R8: record_en is 0 exactly when the mode bit (config address 4, bit 0, reset value 0) is 1 and motionless is 1. Writing the mode bit acts on record_en on the cycle after the write.
- R9: frame_valid pulses for one cycle, two clock edges after the sample that carries both mb_last and frame_last is accepted. motion_frame, motion_mb_count and motionless update at that same edge and hold otherwise.
- R10: After reset, frame_valid, motion_frame, motion_mb_count and motionless are 0 and record_en is 1.
- R11: Writes to config addresses 0 to 3 replace the corresponding threshold, and the new value is used for frames that start after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample pair is present this cycle |
| cur_smp | input | SAMP_W | Current-frame luma sample |
| ref_smp | input | SAMP_W | Reference-frame luma sample |
| mb_last | input | 1 | This pair is the last of its macroblock |
| frame_last | input | 1 | With mb_last: this macroblock ends the frame |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (0 to 6) |
| cfg_wdata | input | 8 | Configuration write data |
| frame_valid | output | 1 | One-cycle pulse when a frame result is updated |
| motion_frame | output | 1 | Last frame had motion |
| motion_mb_count | output | clog2(MB_COLS*MB_ROWS+1) | Enabled moving macroblocks in the last frame |
| motionless | output | 1 | Still-run length has reached its threshold |
| record_en | output | 1 | Recording permitted |

## Verification
The bench first runs frames against the reset thresholds. Each frame moves a chosen number of macroblocks, with a chosen number of different samples per macroblock and a chosen difference size and sign. The runs set one value at a time exactly on a threshold and one step above it, so the strict comparisons at pixel, macroblock and frame level are each separated from an off-by-one, and negative differences are separated from a missing absolute value. A run of still frames then checks when the persistence counter trips, and a motion frame checks that it clears. Mask tests move every macroblock. Only the reported count then shows which groups are enabled, whether the pointer auto-increments, and whether the new mask waits for the frame boundary.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

    // configuration register addresses
    localparam logic [2:0] ADDR_PIX_THR   = 3'd0;
    localparam logic [2:0] ADDR_DIFF_THR  = 3'd1;
    localparam logic [2:0] ADDR_MB_THR    = 3'd2;
    localparam logic [2:0] ADDR_STILL_THR = 3'd3;
    localparam logic [2:0] ADDR_MODE      = 3'd4;
    localparam logic [2:0] ADDR_MASK_DATA = 3'd5;
    localparam logic [2:0] ADDR_MASK_PCLR = 3'd6;

    localparam int PIX_THR_W   = 6;
    localparam int DIFF_THR_W  = 7;
    localparam int MB_THR_W    = 8;
    localparam int STILL_THR_W = 8;

    typedef struct packed {
        logic [PIX_THR_W-1:0]   pix_thr;
        logic [DIFF_THR_W-1:0]  diff_thr;
        logic [MB_THR_W-1:0]    mb_thr;
        logic [STILL_THR_W-1:0] still_thr;
        logic                   hold_mode;
    } mdet_cfg_t;

    localparam mdet_cfg_t CFG_RESET = '{
        pix_thr:   6'd32,
        diff_thr:  7'd32,
        mb_thr:    8'd5,
        still_thr: 8'd5,
        hold_mode: 1'b0
    };

endpackage

// File: rtl/mdet_cfg.sv
module mdet_cfg
    import mdet_pkg::*;
#(
    parameter int MASK_BYTES = 45
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_addr,
    input  logic [7:0]              cfg_wdata,
    input  logic                    commit,
    output mdet_cfg_t               cfg,
    output logic [MASK_BYTES*8-1:0] mask_active
);

    localparam int MASK_BITS = MASK_BYTES * 8;
    localparam int PTR_W     = (MASK_BYTES > 1) ? $clog2(MASK_BYTES) : 1;

    typedef struct packed {
        mdet_cfg_t             regs;
        logic [MASK_BITS-1:0]  shadow;
        logic [MASK_BITS-1:0]  active;
        logic [PTR_W-1:0]      ptr;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_PIX_THR:   st_d.regs.pix_thr   = cfg_wdata[PIX_THR_W-1:0];
                ADDR_DIFF_THR:  st_d.regs.diff_thr  = cfg_wdata[DIFF_THR_W-1:0];
                ADDR_MB_THR:    st_d.regs.mb_thr    = cfg_wdata;
                ADDR_STILL_THR: st_d.regs.still_thr = cfg_wdata;
                ADDR_MODE:      st_d.regs.hold_mode = cfg_wdata[0];
                ADDR_MASK_DATA: begin
                    // bit 7 of the byte becomes the lowest linear group index
                    for (int i = 0; i < 8; i++) begin
                        st_d.shadow[32'(st_q.ptr) * 8 + i] = cfg_wdata[7-i];
                    end
                    if (32'(st_q.ptr) == MASK_BYTES - 1) begin
                        st_d.ptr = '0;
                    end else begin
                        st_d.ptr = st_q.ptr + PTR_W'(1);
                    end
                end
                ADDR_MASK_PCLR: st_d.ptr = '0;
                default: ;
            endcase
        end
        if (commit) begin
            st_d.active = st_d.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs   <= CFG_RESET;
            st_q.shadow <= '1;
            st_q.active <= '1;
            st_q.ptr    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg         = st_q.regs;
    assign mask_active = st_q.active;

endmodule

// File: rtl/mdet_mb_eval.sv
module mdet_mb_eval
    import mdet_pkg::*;
#(
    parameter int SAMP_W     = 8,
    parameter int MB_SAMPLES = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [SAMP_W-1:0]     cur_smp,
    input  logic [SAMP_W-1:0]     ref_smp,
    input  logic                  mb_last,
    input  logic                  frame_last,
    input  logic [PIX_THR_W-1:0]  pix_thr,
    input  logic [DIFF_THR_W-1:0] diff_thr,
    output logic                  mb_done,
    output logic                  mb_moving,
    output logic                  frame_end
);

    localparam int CNT_W = $clog2(MB_SAMPLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             moving;
        logic             fend;
    } mb_state_t;

    mb_state_t         st_d, st_q;
    logic [SAMP_W-1:0] mag;
    logic              is_diff;
    logic [CNT_W-1:0]  cnt_next;

    always_comb begin
        mag      = (cur_smp >= ref_smp) ? (cur_smp - ref_smp) : (ref_smp - cur_smp);
        is_diff  = int'(mag) > int'(pix_thr);
        cnt_next = st_q.cnt + CNT_W'(is_diff);

        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.moving = 1'b0;
        st_d.fend   = 1'b0;
        if (smp_valid) begin
            if (mb_last) begin
                st_d.done   = 1'b1;
                st_d.moving = int'(cnt_next) > int'(diff_thr);
                st_d.fend   = frame_last;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt    = cnt_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mb_done   = st_q.done;
    assign mb_moving = st_q.moving;
    assign frame_end = st_q.fend;

endmodule

// File: rtl/mdet_frame_eval.sv
module mdet_frame_eval
    import mdet_pkg::*;
#(
    parameter int MB_COLS        = 45,
    parameter int MB_ROWS        = 30,
    parameter int MASK_BITS      = 360,
    parameter int GROUP_ROW_BITS = 24,
    parameter int COUNT_W        = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mb_done,
    input  logic                   mb_moving,
    input  logic                   frame_end,
    input  logic [MASK_BITS-1:0]   mask_active,
    input  logic [MB_THR_W-1:0]    mb_thr,
    input  logic [STILL_THR_W-1:0] still_thr,
    output logic                   frame_valid,
    output logic                   motion_frame,
    output logic [COUNT_W-1:0]     motion_mb_count,
    output logic                   motionless
);

    localparam int COL_W = (MB_COLS > 1) ? $clog2(MB_COLS) : 1;
    localparam int ROW_W = (MB_ROWS > 1) ? $clog2(MB_ROWS) : 1;
    localparam int IDX_W = $clog2(MASK_BITS);

    typedef struct packed {
        logic [COL_W-1:0]       col;
        logic [ROW_W-1:0]       row;
        logic [COUNT_W-1:0]     acc;
        logic [STILL_THR_W-1:0] still;
        logic [COUNT_W-1:0]     count;
        logic                   motion;
        logic                   motionless;
        logic                   valid;
    } fr_state_t;

    fr_state_t              st_d, st_q;
    logic [31:0]            bit_idx;
    logic                   enabled;
    logic                   hit;
    logic [COUNT_W-1:0]     acc_next;
    logic [STILL_THR_W-1:0] still_next;

    always_comb begin
        bit_idx  = 32'(st_q.row >> 1) * 32'(GROUP_ROW_BITS) + 32'(st_q.col >> 1);
        enabled  = (bit_idx < 32'(MASK_BITS)) ? mask_active[bit_idx[IDX_W-1:0]] : 1'b0;
        hit      = mb_done && mb_moving && enabled;
        acc_next = st_q.acc + COUNT_W'(hit);
        still_next = (st_q.still == '1) ? st_q.still : st_q.still + STILL_THR_W'(1);

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (mb_done) begin
            if (frame_end) begin
                st_d.col    = '0;
                st_d.row    = '0;
                st_d.acc    = '0;
                st_d.valid  = 1'b1;
                st_d.count  = acc_next;
                st_d.motion = int'(acc_next) > int'(mb_thr);
                if (st_d.motion) begin
                    st_d.still      = '0;
                    st_d.motionless = 1'b0;
                end else begin
                    st_d.still      = still_next;
                    st_d.motionless = still_next >= still_thr;
                end
            end else begin
                st_d.acc = acc_next;
                if (32'(st_q.col) == MB_COLS - 1) begin
                    st_d.col = '0;
                    if (32'(st_q.row) != MB_ROWS - 1) begin
                        st_d.row = st_q.row + ROW_W'(1);
                    end
                end else begin
                    st_d.col = st_q.col + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_valid     = st_q.valid;
    assign motion_frame    = st_q.motion;
    assign motion_mb_count = st_q.count;
    assign motionless      = st_q.motionless;

endmodule

// File: rtl/md_motion_detect.sv
module md_motion_detect
    import mdet_pkg::*;
#(
    parameter int SAMP_W  = 8,
    parameter int MB_DIM  = 16,
    parameter int MB_COLS = 45,
    parameter int MB_ROWS = 30
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  smp_valid,
    input  logic [SAMP_W-1:0]                     cur_smp,
    input  logic [SAMP_W-1:0]                     ref_smp,
    input  logic                                  mb_last,
    input  logic                                  frame_last,
    input  logic                                  cfg_we,
    input  logic [2:0]                            cfg_addr,
    input  logic [7:0]                            cfg_wdata,
    output logic                                  frame_valid,
    output logic                                  motion_frame,
    output logic [$clog2(MB_COLS*MB_ROWS+1)-1:0]  motion_mb_count,
    output logic                                  motionless,
    output logic                                  record_en
);

    localparam int MB_SAMPLES     = MB_DIM * MB_DIM;
    localparam int GROUP_COLS     = (MB_COLS + 1) / 2;
    localparam int GROUP_ROWS     = (MB_ROWS + 1) / 2;
    localparam int BYTES_PER_GROW = (GROUP_COLS + 7) / 8;
    localparam int MASK_BYTES     = GROUP_ROWS * BYTES_PER_GROW;
    localparam int COUNT_W        = $clog2(MB_COLS * MB_ROWS + 1);

    mdet_cfg_t              cfg;
    logic [MASK_BYTES*8-1:0] mask_active;
    logic                   mb_done;
    logic                   mb_moving;
    logic                   frame_end;

    mdet_cfg #(
        .MASK_BYTES (MASK_BYTES)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .commit      (frame_end),
        .cfg         (cfg),
        .mask_active (mask_active)
    );

    mdet_mb_eval #(
        .SAMP_W     (SAMP_W),
        .MB_SAMPLES (MB_SAMPLES)
    ) u_mb_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .cur_smp    (cur_smp),
        .ref_smp    (ref_smp),
        .mb_last    (mb_last),
        .frame_last (frame_last),
        .pix_thr    (cfg.pix_thr),
        .diff_thr   (cfg.diff_thr),
        .mb_done    (mb_done),
        .mb_moving  (mb_moving),
        .frame_end  (frame_end)
    );

    mdet_frame_eval #(
        .MB_COLS        (MB_COLS),
        .MB_ROWS        (MB_ROWS),
        .MASK_BITS      (MASK_BYTES * 8),
        .GROUP_ROW_BITS (BYTES_PER_GROW * 8),
        .COUNT_W        (COUNT_W)
    ) u_frame_eval (
        .clk             (clk),
        .rst_n           (rst_n),
        .mb_done         (mb_done),
        .mb_moving       (mb_moving),
        .frame_end       (frame_end),
        .mask_active     (mask_active),
        .mb_thr          (cfg.mb_thr),
        .still_thr       (cfg.still_thr),
        .frame_valid     (frame_valid),
        .motion_frame    (motion_frame),
        .motion_mb_count (motion_mb_count),
        .motionless      (motionless)
    );

    assign record_en = !(cfg.hold_mode && motionless);

endmodule

// File: rtl/md_motion_detect_chk.sv
module md_motion_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic mb_last,
    input logic frame_last,
    input logic frame_valid,
    input logic motion_frame,
    input logic motionless,
    input logic record_en
);

    // R9
    fv_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(smp_valid && mb_last && frame_last, 2));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(motion_frame) && $stable(motionless)));

    // R5
    motion_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && motion_frame) |-> !motionless);

    // R4
    still_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(motionless) |-> (frame_valid && !motion_frame));

    // R8
    record_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !record_en |-> motionless);

endmodule

bind md_motion_detect md_motion_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .mb_last      (mb_last),
    .frame_last   (frame_last),
    .frame_valid  (frame_valid),
    .motion_frame (motion_frame),
    .motionless   (motionless),
    .record_en    (record_en)
);

// File: tb/md_motion_detect_bench.sv
module md_motion_detect_bench;

    localparam int SAMP_W  = 8;
    localparam int MB_DIM  = 8;
    localparam int MB_COLS = 4;
    localparam int MB_ROWS = 4;
    localparam int MB_SAMP = MB_DIM * MB_DIM;
    localparam int NUM_MB  = MB_COLS * MB_ROWS;
    localparam int CNT_W   = $clog2(NUM_MB + 1);
    localparam int GRP_BITS_PER_ROW = 8;  // one mask byte per group row here
    localparam int MASK_BITS = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [SAMP_W-1:0] cur_smp = '0;
    logic [SAMP_W-1:0] ref_smp = '0;
    logic              mb_last = 1'b0;
    logic              frame_last = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [7:0]        cfg_wdata = '0;
    logic              frame_valid;
    logic              motion_frame;
    logic [CNT_W-1:0]  motion_mb_count;
    logic              motionless;
    logic              record_en;

    always #10 clk = ~clk;

    md_motion_detect #(
        .SAMP_W  (SAMP_W),
        .MB_DIM  (MB_DIM),
        .MB_COLS (MB_COLS),
        .MB_ROWS (MB_ROWS)
    ) u_md_motion_detect (
        .clk             (clk),
        .rst_n           (rst_n),
        .smp_valid       (smp_valid),
        .cur_smp         (cur_smp),
        .ref_smp         (ref_smp),
        .mb_last         (mb_last),
        .frame_last      (frame_last),
        .cfg_we          (cfg_we),
        .cfg_addr        (cfg_addr),
        .cfg_wdata       (cfg_wdata),
        .frame_valid     (frame_valid),
        .motion_frame    (motion_frame),
        .motion_mb_count (motion_mb_count),
        .motionless      (motionless),
        .record_en       (record_en)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int fv_pulses = 0;

    always @(posedge clk) if (rst_n && frame_valid) fv_pulses++;

    // reference model state, built from the requirements
    int   m_pix = 32, m_diff = 32, m_mb = 5, m_still = 5, m_mode = 0;
    int   m_run = 0, m_motionless = 0, m_count = 0, m_motion = 0, m_ptr = 0;
    logic m_shadow [MASK_BITS];
    logic m_active [MASK_BITS];

    typedef struct packed {
        logic [7:0] nmov;
        logic [7:0] k;
        logic [7:0] d;
        logic       neg;
    } fvec_t;

    // frames against reset thresholds
    localparam fvec_t VECS [0:9] = '{
        '{8'd6,  8'd33, 8'd33, 1'b0},  // R3: 6 > 5 motion
        '{8'd5,  8'd33, 8'd33, 1'b0},  // R3: 5 not above 5
        '{8'd16, 8'd33, 8'd32, 1'b0},  // R1: diff equal to threshold
        '{8'd16, 8'd32, 8'd40, 1'b0},  // R2: count equal to threshold
        '{8'd7,  8'd40, 8'd50, 1'b1},  // R1: negative differences
        '{8'd0,  8'd0,  8'd0,  1'b0},  // R4: still run 1
        '{8'd0,  8'd0,  8'd0,  1'b0},
        '{8'd0,  8'd0,  8'd0,  1'b0},
        '{8'd0,  8'd0,  8'd0,  1'b0},  // still run 4
        '{8'd0,  8'd0,  8'd0,  1'b0}   // still run 5: motionless
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] addr, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (addr)
            3'd0: m_pix   = int'(data[5:0]);
            3'd1: m_diff  = int'(data[6:0]);
            3'd2: m_mb    = int'(data);
            3'd3: m_still = int'(data);
            3'd4: m_mode  = int'(data[0]);
            3'd5: begin
                for (int i = 0; i < 8; i++) m_shadow[m_ptr*8+i] = data[7-i];
                m_ptr = (m_ptr == MASK_BITS/8 - 1) ? 0 : m_ptr + 1;
            end
            3'd6: m_ptr = 0;
            default: ;
        endcase
    endtask

    task automatic run_frame(input int nmov, input int k, input int d, input bit neg);
        int cnt;
        int fv0;
        fv0 = fv_pulses;
        for (int mb = 0; mb < NUM_MB; mb++) begin
            for (int s = 0; s < MB_SAMP; s++) begin
                @(negedge clk);
                smp_valid  = 1'b1;
                ref_smp    = 8'd100;
                if (mb < nmov && s < k) cur_smp = neg ? 8'(100 - d) : 8'(100 + d);
                else cur_smp = 8'd100;
                mb_last    = (s == MB_SAMP - 1);
                frame_last = (s == MB_SAMP - 1) && (mb == NUM_MB - 1);
            end
        end
        @(negedge clk);
        smp_valid = 1'b0; mb_last = 1'b0; frame_last = 1'b0;
        // model
        cnt = 0;
        for (int mb = 0; mb < NUM_MB; mb++) begin
            int col = mb % MB_COLS;
            int row = mb / MB_COLS;
            int idx = (row / 2) * GRP_BITS_PER_ROW + col / 2;
            if (mb < nmov && d > m_pix && k > m_diff && m_active[idx]) cnt++;
        end
        for (int i = 0; i < MASK_BITS; i++) m_active[i] = m_shadow[i];
        m_count  = cnt;
        m_motion = (cnt > m_mb) ? 1 : 0;
        if (m_motion != 0) begin
            m_run = 0; m_motionless = 0;
        end else begin
            if (m_run < 255) m_run++;
            m_motionless = (m_run >= m_still) ? 1 : 0;
        end
        @(negedge clk);
        @(negedge clk);
        check("R9 one frame_valid pulse", fv_pulses - fv0, 1);
    endtask

    task automatic check_result(input string tag);
        check({tag, " R3 count"}, int'(motion_mb_count), m_count);
        check({tag, " R3 motion_frame"}, int'(motion_frame), m_motion);
        check({tag, " R4 motionless"}, int'(motionless), m_motionless);
        check({tag, " R8 record_en"}, int'(record_en), (m_mode != 0 && m_motionless != 0) ? 0 : 1);
    endtask

    initial begin
        for (int i = 0; i < MASK_BITS; i++) begin
            m_shadow[i] = 1'b1;
            m_active[i] = 1'b1;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 frame_valid", int'(frame_valid), 0);
        check("R10 motion_frame", int'(motion_frame), 0);
        check("R10 count", int'(motion_mb_count), 0);
        check("R10 motionless", int'(motionless), 0);
        check("R10 record_en", int'(record_en), 1);

        // R1 R2 R3 R4 with reset thresholds
        for (int v = 0; v < 10; v++) begin
            run_frame(int'(VECS[v].nmov), int'(VECS[v].k), int'(VECS[v].d), VECS[v].neg);
            check_result($sformatf("vec%0d R1/R2", v));
        end
        check("R4 motionless after five still frames", int'(motionless), 1);

        // R8 hold mode gates recording while motionless
        cfg_write(3'd4, 8'h01);
        check("R8 record_en low when held", int'(record_en), 0);

        // R5 motion frame clears the still run
        run_frame(16, 40, 40, 1'b0);
        check_result("R5 clear");
        check("R5 motionless cleared", int'(motionless), 0);

        // R11 new thresholds
        cfg_write(3'd0, 8'd10);
        cfg_write(3'd1, 8'd4);
        cfg_write(3'd2, 8'd3);
        cfg_write(3'd3, 8'd1);
        run_frame(4, 5, 11, 1'b0);
        check_result("R11 new thresholds");
        run_frame(0, 0, 0, 1'b0);
        check_result("R11 still threshold one");
        check("R4 still threshold one", int'(motionless), 1);
        run_frame(3, 5, 11, 1'b0);
        check_result("R11 count at mb threshold");

        // R6 R7 mask: only group row 0 col 1 enabled
        cfg_write(3'd6, 8'h00);
        cfg_write(3'd5, 8'h40);
        cfg_write(3'd5, 8'h00);
        run_frame(16, 5, 11, 1'b0);
        check("R7 mask deferred", int'(motion_mb_count), 16);
        run_frame(16, 5, 11, 1'b0);
        check("R6 one group enabled", int'(motion_mb_count), 4);
        check_result("R6 mask");

        // R7 auto-increment: groups (0,0),(0,1),(1,0)
        cfg_write(3'd6, 8'h00);
        cfg_write(3'd5, 8'hC0);
        cfg_write(3'd5, 8'h80);
        run_frame(16, 5, 11, 1'b0);
        check("R7 old mask held during frame", int'(motion_mb_count), 4);
        run_frame(16, 5, 11, 1'b0);
        check("R7 auto-increment mask", int'(motion_mb_count), 12);
        check_result("R7 mask");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule